// File: doc/BRIEF.md
# Scatter-Gather DMA Channel Register File

This block holds the software-visible control and status state for a two-channel scatter-gather DMA. A host reaches it over a plain 32-bit word bus with one write strobe and one read strobe. From the address it works out which channel and which register an access targets. It then applies the start, stop and soft-reset rules to that channel and keeps the halted and idle flags up to date.

The descriptor-walking engine and the interrupt-coalescing counters sit outside this block. The engine reports back through per-channel set inputs for halted, idle and the three interrupt-pending causes. The counters feed their live values into the upper bytes of every status read. The block drives one interrupt line per channel. It exports each channel's current and tail descriptor pointers, and it gives a one-cycle kick to the engine whenever software writes the tail pointer of the transmit channel (channel 0). A soft reset stays pending until software reads the control register, which lets software see a one-access reset delay.

Top module: `sgdma_csr`

## Requirements
- R1: Each channel occupies a 48-byte window. The channel index is (address / 48) mod 2, so windows repeat every 96 bytes. Inside a window the word offsets are 0x00 control, 0x04 status, 0x08 current descriptor and 0x10 tail descriptor. Every other word offset, including the current-descriptor word, is a plain 32-bit register that reads back what was last written.
- R2: After the synchronous reset, a control read returns 0x00010000 (threshold byte 23:16 equal to 1) and the stored status is 0x0001 (halted only).
- R3: A control write stores the written word with bit 1 (tail-pointer mode) forced to 1. With no soft reset involved, the read returns the written value OR 0x2.
- R4: A control write whose bit 2 is set, or any control write made while a soft reset is still pending, returns the channel's control to threshold 1 with bits 2 and 1 set, and its status to 0x0001. A control read returns the word with bit 2 shown as 0 and clears the pending reset. Pointers and plain registers are left unchanged.
- R5: A control write with bit 0 (run) set and no reset pending clears status bits 0 (halted) and 1 (idle). While a reset is pending, a run write leaves halted set.
- R6: A tail-pointer write stores the pointer and clears idle. When it targets channel 0, `kick` is high for exactly the following cycle. A tail write on channel 1 gives no kick.
- R7: A status read returns the channel's delay-timer count in bits 31:24, its completion count in bits 23:16 and the stored status in bits 15:0.
- R8: A status write stores bits 15:0 of the written word with bits 14:12 forced to 0, so it clears all pending interrupt causes.
- R9: The engine's set inputs OR into status bit 0 (halt), bit 1 (idle) and bits 14:12 (pending). They are applied after a bus write in the same cycle, so they win over it.
- R10: A channel's `irq` is high exactly when some bit of status 14:12 is set together with the same bit of control 14:12.
- R11: `bus_rdata` takes the addressed value on the clock edge where `bus_rd` is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| halt_set | input | NCH | Per-channel engine request to set halted |
| idle_set | input | NCH | Per-channel engine request to set idle |
| pend_set | input | NCH x 3 | Per-channel interrupt causes to mark pending |
| cmpl_cnt | input | NCH x 8 | Per-channel completion counter value |
| dly_cnt | input | NCH x 8 | Per-channel delay-timer count |
| irq | output | NCH | Per-channel interrupt |
| kick | output | 1 | One-cycle start pulse after a channel 0 tail write |
| cur_desc | output | NCH x 32 | Per-channel current descriptor pointer |
| tail_desc | output | NCH x 32 | Per-channel tail descriptor pointer |

## Verification
The decoder is swept over every word address of the 8-bit space. Because windows alias, each register is written through several addresses, and only the last write through any alias may survive; this separates a correct divide-and-modulo decode from a plain bit-slice decode. Control sequences try run, soft reset, run under a pending reset and the clearing read in turn, which separates the pending-reset path from the normal write path. The interrupt mask is tried against all 64 pairs of pending causes and enable bits. Separate patterns check counter bytes in the status view, a status write racing an engine set, and tail writes on each channel for the kick.

// File: rtl/sgdma_csr_pkg.sv
`timescale 1ns/1ps
package sgdma_csr_pkg;

    localparam int NCH       = 2;
    localparam int CH_W      = 1;
    localparam int DW        = 32;
    localparam int WIN_BYTES = 48;
    localparam int WIN_WORDS = WIN_BYTES / 4;
    localparam int WORD_W    = $clog2(WIN_WORDS);
    localparam int STORE_N   = 1 << WORD_W;

    // word offsets that carry behaviour
    localparam int W_CTRL = 0;
    localparam int W_STAT = 1;
    localparam int W_CUR  = 2;
    localparam int W_TAIL = 4;

    // control / status bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_TMOD = 1;
    localparam int CB_SRST = 2;
    localparam int SB_HALT = 0;
    localparam int SB_IDLE = 1;
    localparam int PEND_LO = 12;
    localparam int PEND_W  = 3;

    localparam logic [DW-1:0] CTRL_POR  = 32'h0001_0000;
    localparam logic [15:0]   STAT_POR  = 16'h0001;
    localparam logic [15:0]   PEND_MSK  = 16'h7000;
    localparam logic [NCH-1:0] KICK_MSK = NCH'(1);

    typedef enum logic [1:0] {
        K_CTRL,
        K_STAT,
        K_TAIL,
        K_PLAIN
    } reg_kind_e;

    typedef struct packed {
        logic [CH_W-1:0]   ch;
        logic [WORD_W-1:0] word;
        reg_kind_e         kind;
    } acc_t;

    // control write value: mode bit forced, pending reset carried over
    function automatic logic [DW-1:0] ctrl_merge(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] wr_v);
        logic [DW-1:0] v;
        v = wr_v;
        v[CB_TMOD] = 1'b1;
        v[CB_SRST] = wr_v[CB_SRST] | old_v[CB_SRST];
        return v;
    endfunction

    function automatic logic [DW-1:0] stat_view(input logic [15:0] st,
                                                input logic [7:0]  cmpl,
                                                input logic [7:0]  dly);
        return {dly, cmpl, st};
    endfunction

endpackage

// File: rtl/sgdma_csr_decode.sv
`timescale 1ns/1ps
module sgdma_csr_decode
    import sgdma_csr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    output acc_t          acc
);
    localparam logic [AW-1:0] WIN_B = AW'(WIN_BYTES);
    localparam logic [AW-1:0] NCH_A = AW'(NCH);

    always_comb begin
        acc.ch   = CH_W'((addr / WIN_B) % NCH_A);
        acc.word = WORD_W'((addr % WIN_B) >> 2);
        case (int'(acc.word))
            W_CTRL:  acc.kind = K_CTRL;
            W_STAT:  acc.kind = K_STAT;
            W_TAIL:  acc.kind = K_TAIL;
            default: acc.kind = K_PLAIN;
        endcase
    end
endmodule

// File: rtl/sgdma_csr_chan.sv
`timescale 1ns/1ps
module sgdma_csr_chan
    import sgdma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  acc_t              acc,
    input  logic [DW-1:0]     wdata,
    input  logic              halt_set,
    input  logic              idle_set,
    input  logic [PEND_W-1:0] pend_set,
    input  logic [7:0]        cmpl_cnt,
    input  logic [7:0]        dly_cnt,
    output logic [DW-1:0]     rdata,
    output logic              irq,
    output logic              tail_wr,
    output logic              halted,
    output logic [DW-1:0]     ctrl_o,
    output logic [DW-1:0]     cur_o,
    output logic [DW-1:0]     tail_o
);
    logic [DW-1:0] ctrl_q, ctrl_n;
    logic [15:0]   stat_q, stat_n;
    logic [DW-1:0] store_q [STORE_N];
    logic [DW-1:0] merged;

    always_comb begin
        ctrl_n = ctrl_q;
        stat_n = stat_q;
        merged = ctrl_merge(ctrl_q, wdata);
        if (wr) begin
            case (acc.kind)
                K_CTRL: begin
                    if (merged[CB_SRST]) begin
                        ctrl_n = CTRL_POR;
                        ctrl_n[CB_TMOD] = 1'b1;
                        ctrl_n[CB_SRST] = 1'b1;
                        stat_n = STAT_POR;
                    end else begin
                        ctrl_n = merged;
                        if (merged[CB_RUN]) begin
                            stat_n[SB_HALT] = 1'b0;
                            stat_n[SB_IDLE] = 1'b0;
                        end
                    end
                end
                K_STAT:  stat_n = wdata[15:0] & ~PEND_MSK;
                K_TAIL:  stat_n[SB_IDLE] = 1'b0;
                default: ;
            endcase
        end
        if (rd && acc.kind == K_CTRL) begin
            ctrl_n[CB_SRST] = 1'b0;
        end
        // engine reports win over a same-cycle bus write
        stat_n[SB_HALT] = stat_n[SB_HALT] | halt_set;
        stat_n[SB_IDLE] = stat_n[SB_IDLE] | idle_set;
        stat_n[PEND_LO +: PEND_W] = stat_n[PEND_LO +: PEND_W] | pend_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_POR;
            stat_q <= STAT_POR;
        end else begin
            ctrl_q <= ctrl_n;
            stat_q <= stat_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STORE_N; i++) begin
                store_q[i] <= '0;
            end
        end else if (wr && (acc.kind == K_PLAIN || acc.kind == K_TAIL)) begin
            store_q[acc.word] <= wdata;
        end
    end

    always_comb begin
        case (acc.kind)
            K_CTRL: begin
                rdata = ctrl_q;
                rdata[CB_SRST] = 1'b0;
            end
            K_STAT:  rdata = stat_view(stat_q, cmpl_cnt, dly_cnt);
            default: rdata = store_q[acc.word];
        endcase
    end

    assign tail_wr = wr && (acc.kind == K_TAIL);
    assign irq     = |(stat_q[PEND_LO +: PEND_W] & ctrl_q[PEND_LO +: PEND_W]);
    assign halted  = stat_q[SB_HALT];
    assign ctrl_o  = ctrl_q;
    assign cur_o   = store_q[W_CUR];
    assign tail_o  = store_q[W_TAIL];
endmodule

// File: rtl/sgdma_csr.sv
`timescale 1ns/1ps
module sgdma_csr
    import sgdma_csr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [AW-1:0]                 bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic [NCH-1:0]                halt_set,
    input  logic [NCH-1:0]                idle_set,
    input  logic [NCH-1:0][PEND_W-1:0]    pend_set,
    input  logic [NCH-1:0][7:0]           cmpl_cnt,
    input  logic [NCH-1:0][7:0]           dly_cnt,
    output logic [NCH-1:0]                irq,
    output logic                          kick,
    output logic [NCH-1:0][31:0]          cur_desc,
    output logic [NCH-1:0][31:0]          tail_desc
);
    acc_t                   acc;
    logic [NCH-1:0][DW-1:0] rd_vec;
    logic [NCH-1:0][DW-1:0] ch_ctrl;
    logic [NCH-1:0]         ch_halt;
    logic [NCH-1:0]         tail_wr;

    sgdma_csr_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .acc  (acc)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sgdma_csr_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr       (bus_wr && (int'(acc.ch) == c)),
            .rd       (bus_rd && (int'(acc.ch) == c)),
            .acc      (acc),
            .wdata    (bus_wdata),
            .halt_set (halt_set[c]),
            .idle_set (idle_set[c]),
            .pend_set (pend_set[c]),
            .cmpl_cnt (cmpl_cnt[c]),
            .dly_cnt  (dly_cnt[c]),
            .rdata    (rd_vec[c]),
            .irq      (irq[c]),
            .tail_wr  (tail_wr[c]),
            .halted   (ch_halt[c]),
            .ctrl_o   (ch_ctrl[c]),
            .cur_o    (cur_desc[c]),
            .tail_o   (tail_desc[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            kick      <= 1'b0;
        end else begin
            kick <= |(tail_wr & KICK_MSK);
            if (bus_rd) begin
                bus_rdata <= rd_vec[acc.ch];
            end
        end
    end
endmodule

// File: rtl/sgdma_csr_chk.sv
`timescale 1ns/1ps
module sgdma_csr_chk
    import sgdma_csr_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [31:0]                bus_rdata,
    input logic [NCH-1:0]             halt_set,
    input logic [NCH-1:0][PEND_W-1:0] pend_set,
    input logic [NCH-1:0]             irq,
    input logic                       kick,
    input logic [NCH-1:0][DW-1:0]     ch_ctrl,
    input logic [NCH-1:0]             ch_halt
);
    AST_KICK_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        kick |-> $past(bus_wr)); // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> $stable(bus_rdata)); // R11

    for (genvar c = 0; c < NCH; c++) begin : g_c
        AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[c]) |-> ($past(pend_set[c]) != '0 || $past(bus_wr))); // R10

        AST_HALT_STICKS: assert property (@(posedge clk) disable iff (rst)
            halt_set[c] |=> ch_halt[c]); // R9

        AST_MODE_FORCED: assert property (@(posedge clk) disable iff (rst)
            !ch_ctrl[c][CB_TMOD] |-> (ch_ctrl[c] == CTRL_POR)); // R3
    end
endmodule

bind sgdma_csr sgdma_csr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .halt_set  (halt_set),
    .pend_set  (pend_set),
    .irq       (irq),
    .kick      (kick),
    .ch_ctrl   (ch_ctrl),
    .ch_halt   (ch_halt)
);

// File: tb/sgdma_csr_test.sv
`timescale 1ns/1ps
module sgdma_csr_test;
    import sgdma_csr_pkg::*;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       bus_wr = 1'b0;
    logic                       bus_rd = 1'b0;
    logic [7:0]                 bus_addr = '0;
    logic [31:0]                bus_wdata = '0;
    logic [31:0]                bus_rdata;
    logic [NCH-1:0]             halt_set = '0;
    logic [NCH-1:0]             idle_set = '0;
    logic [NCH-1:0][PEND_W-1:0] pend_set = '0;
    logic [NCH-1:0][7:0]        cmpl_cnt = '0;
    logic [NCH-1:0][7:0]        dly_cnt = '0;
    logic [NCH-1:0]             irq;
    logic                       kick;
    logic [NCH-1:0][31:0]       cur_desc;
    logic [NCH-1:0][31:0]       tail_desc;

    int n_chk  = 0;
    int n_fail = 0;
    int kicks  = 0;

    always #4 clk = ~clk;

    sgdma_csr uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .halt_set(halt_set), .idle_set(idle_set), .pend_set(pend_set),
        .cmpl_cnt(cmpl_cnt), .dly_cnt(dly_cnt), .irq(irq), .kick(kick),
        .cur_desc(cur_desc), .tail_desc(tail_desc)
    );

    always @(posedge clk) if (!rst && kick) kicks <= kicks + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] base(input int c);
        return 8'(c * 48);
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] mdl [2][16];
        int          k0;
        int          exp_k;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R2: reset values on both channels
        for (int c = 0; c < 2; c++) begin
            do_rd(base(c) + 8'h00, v); check("R2 ctrl", v, 32'h0001_0000);
            do_rd(base(c) + 8'h04, v); check("R2 status", v, 32'h0000_0001);
        end

        // R1 / R6: sweep every word address, aliases included
        for (int c = 0; c < 2; c++) for (int w = 0; w < 16; w++) mdl[c][w] = '0;
        k0 = kicks; exp_k = 0;
        for (int a = 0; a < 256; a += 4) begin
            int w, c;
            w = (a % 48) / 4; c = (a / 48) % 2;
            if (w > 1) begin
                do_wr(8'(a), {8'hA5, 8'(a), ~8'(a), 8'h5A});
                mdl[c][w] = {8'hA5, 8'(a), ~8'(a), 8'h5A};
                if (w == 4 && c == 0) exp_k++;
            end
        end
        repeat (2) @(negedge clk);
        check("R6 kick count ch0 tail writes", 32'(kicks - k0), 32'(exp_k));
        for (int a = 0; a < 256; a += 4) begin
            int w, c;
            w = (a % 48) / 4; c = (a / 48) % 2;
            if (w > 1) begin
                do_rd(8'(a), v);
                check($sformatf("R1 readback addr %0h", a), v, mdl[c][w]);
            end
        end
        for (int c = 0; c < 2; c++) begin
            check("R1 cur_desc port", cur_desc[c], mdl[c][2]);
            check("R6 tail_desc port", tail_desc[c], mdl[c][4]);
        end

        // R3: mode bit forced on ch1
        do_wr(base(1), 32'h0000_1000);
        do_rd(base(1), v); check("R3 ctrl mode forced", v, 32'h0000_1002);
        do_wr(base(1), 32'h0000_0000);
        do_rd(base(1), v); check("R3 ctrl zero write", v, 32'h0000_0002);
        do_rd(base(1) + 4, v); check("R3 status untouched", v, 32'h0000_0001);

        // R5: run clears halted and idle
        do_wr(base(1), 32'h1);
        do_rd(base(1) + 4, v); check("R5 run clears halted", v, 32'h0);
        do_rd(base(1), v); check("R5 ctrl run", v, 32'h3);
        @(negedge clk); idle_set[1] = 1'b1; @(negedge clk); idle_set = '0;
        do_rd(base(1) + 4, v); check("R9 idle set", v, 32'h2);
        @(negedge clk); halt_set[1] = 1'b1; @(negedge clk); halt_set = '0;
        do_rd(base(1) + 4, v); check("R9 halt set", v, 32'h3);
        do_wr(base(1), 32'h1);
        do_rd(base(1) + 4, v); check("R5 run again clears both", v, 32'h0);

        // R6: tail on ch1 clears idle, no kick
        @(negedge clk); idle_set[1] = 1'b1; @(negedge clk); idle_set = '0;
        k0 = kicks;
        do_wr(base(1) + 8'h10, 32'h0000_4400);
        check("R6 ch1 no kick at port", {31'b0, kick}, 32'h0);
        repeat (2) @(negedge clk);
        check("R6 ch1 kick count", 32'(kicks - k0), 32'h0);
        do_rd(base(1) + 4, v); check("R6 tail clears idle", v, 32'h0);
        check("R6 tail stored", tail_desc[1], 32'h0000_4400);
        do_wr(base(0) + 8'h10, 32'h0000_8800);
        check("R6 ch0 kick pulse", {31'b0, kick}, 32'h1);
        @(negedge clk);
        check("R6 kick one cycle", {31'b0, kick}, 32'h0);

        // R4: soft reset and pending reset on ch0
        do_wr(base(0), 32'h1);
        do_wr(base(0), 32'h5);
        do_rd(base(0) + 4, v); check("R4 reset status", v, 32'h1);
        do_wr(base(0), 32'h1);
        do_rd(base(0) + 4, v); check("R5 run under pending reset", v, 32'h1);
        do_rd(base(0), v); check("R4 ctrl read hides reset", v, 32'h0001_0002);
        do_rd(base(0), v); check("R4 second read", v, 32'h0001_0002);
        check("R4 pointer kept", tail_desc[0], 32'h0000_8800);
        do_wr(base(0), 32'h1);
        do_rd(base(0) + 4, v); check("R4 run after clearing read", v, 32'h0);
        do_rd(base(0), v); check("R4 ctrl after clear", v, 32'h3);

        // R7: counter bytes in status view
        for (int x = 0; x < 256; x += 51) begin
            cmpl_cnt[1] = 8'(x); dly_cnt[1] = 8'(255 - x);
            do_rd(base(1) + 4, v);
            check("R7 status view", v, {8'(255 - x), 8'(x), 16'h0});
            do_rd(base(0) + 4, v);
            check("R7 other channel", v, 32'h0);
        end
        cmpl_cnt = '0; dly_cnt = '0;

        // R8 / R9 / R10: all mask and pending pairs on ch1
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 8; p++) begin
                do_wr(base(1), 32'(m) << 12);
                do_wr(base(1) + 4, 32'h0);
                @(negedge clk); pend_set[1] = 3'(p); @(negedge clk); pend_set = '0;
                check($sformatf("R10 irq m=%0d p=%0d", m, p), {31'b0, irq[1]},
                      {31'b0, ((m & p) != 0)});
                check("R10 ch0 quiet", {31'b0, irq[0]}, 32'h0);
                do_rd(base(1) + 4, v);
                check("R9 pending bits", v, 32'(p) << 12);
                do_wr(base(1) + 4, 32'h0);
                check("R8 clear drops irq", {31'b0, irq[1]}, 32'h0);
            end
        end
        do_wr(base(1) + 4, 32'h0000_FFFF);
        do_rd(base(1) + 4, v); check("R8 status write masks pending", v, 32'h0000_8FFF);
        do_wr(base(1) + 4, 32'hFFFF_0000);
        do_rd(base(1) + 4, v); check("R8 upper half not stored", v, 32'h0);

        // R9: engine set wins over same-cycle status write
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = base(1) + 4; bus_wdata = 32'h0; halt_set[1] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; halt_set = '0;
        do_rd(base(1) + 4, v); check("R9 set beats write", v, 32'h1);

        // R11: read data holds between reads
        do_rd(base(1), v); check("R11 read value", v, 32'h7002);
        do_wr(base(1) + 8'h0C, 32'hDEAD_0001);
        repeat (3) @(negedge clk);
        check("R11 rdata held", bus_rdata, 32'h7002);

        finish_run();
    end
endmodule